// File: doc/BRIEF.md
# Power-Conscious Two-Partition Scan Wrapper

This wrapper surrounds a core whose scanned flip-flops are split into two sub-chains. A registered chain mode chooses between two shapes. The first is a single long chain fed from one test-access wire, with sub-chain 1 filled before sub-chain 2. The second is two parallel chains, each with its own test-access input and output wire. Input steering sends the incoming test bit to the sub-chain being loaded. Per-partition clock enables keep any sub-chain that is not loading frozen. In single-chain mode only one partition toggles at a time, so shift activity is roughly halved. An output selector places the right sub-chain's response on the right output wire.

A position counter runs while single-chain shifting is in progress. It decides when loading moves from sub-chain 1 to sub-chain 2. It wraps after a full pattern and clears whenever shifting pauses. A mode request made while shifting is held off and only takes effect once shifting stops. With test mode off, both partition clocks run freely and the test-access outputs stay at zero.

The shift path is a plain bit-per-cycle scan stream. It has no back-pressure, because a scan shift cannot be stalled part-way by the core. The shift-enable pin is the only qualifier: one bit moves on every clock while it is high. Sub-chain index 0 is partition 1 on every two-bit pin.

Top module: `flex_scan_wrapper`

## Requirements
- R1: After reset the chain mode is single (mode encoding 0 = single chain, 1 = two chains). The position counter is zero, so with test mode on and shift-enable low both clock enables are 1 and `tam_out` is 2'b00.
- R2: In single mode, for the first `L1` shift cycles of a pattern: `part_ce` is 2'b01, `part_si[0]` equals `tam_in[0]`, `part_si[1]` is 0, and `tam_out[0]` equals `part_so[0]`.
- R3: In single mode, for the next `L2` shift cycles: `part_ce` is 2'b10, `part_si[1]` equals `tam_in[0]`, `part_si[0]` is 0, and `tam_out[0]` equals `part_so[1]`.
- R4: After `L1+L2` consecutive single-mode shift cycles, the next shift cycle is again in the sub-chain 1 phase.
- R5: Any cycle with shift-enable low restarts the pattern, so the next shift cycle is in the sub-chain 1 phase.
- R6: In two-chain mode while shifting: `part_ce` is 2'b11, `part_si` equals `tam_in` bit for bit, and `tam_out[i]` equals `part_so[i]`.
- R7: In single mode `tam_out[1]` is always 0.
- R8: `mode_req` is sampled only at clock edges where shift-enable is low. A request raised during shifting has no effect until the first such edge.
- R9: With `test_mode` low, `part_ce` is 2'b11, and `part_si` and `tam_out` are 2'b00.
- R10: With test mode on and shift-enable low, `part_ce` is 2'b11 and `part_si` and `tam_out` are 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_mode | input | 1 | 1 = wrapper in test, 0 = functional |
| shift_en | input | 1 | 1 = scan shift this cycle |
| mode_req | input | 1 | Requested chain mode (0 single, 1 two chains) |
| tam_in | input | 2 | Test-access input wires |
| tam_out | output | 2 | Test-access output wires |
| part_si | output | 2 | Scan-in bit to each sub-chain |
| part_so | input | 2 | Scan-out bit from each sub-chain |
| part_ce | output | 2 | Clock enable of each sub-chain |

## Verification
The bench holds a behavioural model of the wrapper and of both sub-chains, and compares every output on every cycle. Long runs of unbroken single-mode shifting separate the phase boundary from the wrap point. Short bursts broken by single idle cycles show whether the counter restarts or wrongly carries on. Mode requests are toggled both during shifting and between bursts, which separates a deferred mode change from an immediate one. Functional-mode stretches with shift-enable high confirm that nothing leaks onto the test wires.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  typedef enum logic {
    CHAIN_SINGLE = 1'b0,
    CHAIN_DUAL   = 1'b1
  } chain_mode_e;
endpackage

// File: rtl/fsw_mode_reg.sv
module fsw_mode_reg
  import fsw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        shift_en,
  input  logic        mode_req,
  output chain_mode_e mode_q
);
  // requests are only accepted between shift bursts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= CHAIN_SINGLE;
    else if (!shift_en) mode_q <= chain_mode_e'(mode_req);
  end
endmodule

// File: rtl/fsw_phase_ctr.sv
module fsw_phase_ctr #(
  parameter int L1 = 5,
  parameter int L2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic [$clog2(L1+L2)-1:0] pos,
  output logic second
);
  localparam int TOTAL = L1 + L2;
  localparam int CW    = $clog2(TOTAL);
  localparam logic [CW-1:0] LAST  = CW'(TOTAL - 1);
  localparam logic [CW-1:0] SPLIT = CW'(L1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pos <= '0;
    else if (!run)        pos <= '0;
    else if (pos == LAST) pos <= '0;
    else                  pos <= pos + 1'b1;
  end

  assign second = (pos >= SPLIT);
endmodule

// File: rtl/fsw_steer.sv
module fsw_steer
  import fsw_pkg::*;
(
  input  logic        test_mode,
  input  logic        shift_en,
  input  chain_mode_e mode_q,
  input  logic        second,
  input  logic [1:0]  tam_in,
  input  logic [1:0]  part_so,
  output logic [1:0]  tam_out,
  output logic [1:0]  part_si,
  output logic [1:0]  part_ce
);
  always_comb begin
    part_ce = 2'b11;
    part_si = 2'b00;
    tam_out = 2'b00;
    if (test_mode && shift_en) begin
      if (mode_q == CHAIN_DUAL) begin
        part_si = tam_in;
        tam_out = part_so;
      end else if (!second) begin
        part_ce    = 2'b01;
        part_si[0] = tam_in[0];
        tam_out[0] = part_so[0];
      end else begin
        part_ce    = 2'b10;
        part_si[1] = tam_in[0];
        tam_out[0] = part_so[1];
      end
    end
  end
endmodule

// File: rtl/flex_scan_wrapper.sv
module flex_scan_wrapper
  import fsw_pkg::*;
#(
  parameter int L1 = 5,
  parameter int L2 = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       test_mode,
  input  logic       shift_en,
  input  logic       mode_req,
  input  logic [1:0] tam_in,
  output logic [1:0] tam_out,
  output logic [1:0] part_si,
  input  logic [1:0] part_so,
  output logic [1:0] part_ce
);
  localparam int CW = $clog2(L1 + L2);

  chain_mode_e   mode_q;
  logic [CW-1:0] pos;
  logic          second;
  logic          run;

  assign run = test_mode && shift_en && (mode_q == CHAIN_SINGLE);

  fsw_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
    .mode_req(mode_req), .mode_q(mode_q)
  );

  fsw_phase_ctr #(.L1(L1), .L2(L2)) u_ctr (
    .clk(clk), .rst_n(rst_n), .run(run), .pos(pos), .second(second)
  );

  fsw_steer u_steer (
    .test_mode(test_mode), .shift_en(shift_en), .mode_q(mode_q),
    .second(second), .tam_in(tam_in), .part_so(part_so),
    .tam_out(tam_out), .part_si(part_si), .part_ce(part_ce)
  );
endmodule

// File: rtl/fsw_checker.sv
module fsw_checker #(
  parameter int L1 = 5,
  parameter int L2 = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       test_mode,
  input logic       shift_en,
  input logic       mode_bit,
  input logic [$clog2(L1+L2)-1:0] pos,
  input logic [1:0] tam_in,
  input logic [1:0] tam_out,
  input logic [1:0] part_si,
  input logic [1:0] part_so,
  input logic [1:0] part_ce
);
  a_r2_first_part: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && shift_en && !mode_bit && pos < L1) |->
      (part_ce == 2'b01 && tam_out[0] == part_so[0] && part_si[0] == tam_in[0]));

  a_r3_second_part: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && shift_en && !mode_bit && pos >= L1) |->
      (part_ce == 2'b10 && tam_out[0] == part_so[1] && part_si[1] == tam_in[0]));

  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> (pos == 0));

  a_r6_dual: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && shift_en && mode_bit) |->
      (part_ce == 2'b11 && tam_out == part_so && part_si == tam_in));

  a_r7_idle_wire: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_bit |-> (tam_out[1] == 1'b0));

  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_bit) |-> !$past(shift_en));

  a_r9_functional: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> (part_ce == 2'b11 && tam_out == 2'b00 && part_si == 2'b00));

  a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !shift_en) |-> (part_ce == 2'b11 && tam_out == 2'b00));
endmodule

bind flex_scan_wrapper fsw_checker #(.L1(L1), .L2(L2)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .shift_en(shift_en),
  .mode_bit(mode_q), .pos(pos), .tam_in(tam_in), .tam_out(tam_out),
  .part_si(part_si), .part_so(part_so), .part_ce(part_ce)
);

// File: tb/flex_scan_wrapper_test.sv
module flex_scan_wrapper_test;
  localparam int L1 = 5;
  localparam int L2 = 3;
  localparam int TOTAL = L1 + L2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_mode = 1'b1, shift_en = 1'b0, mode_req = 1'b0;
  logic [1:0] tam_in = 2'b00, part_so = 2'b00;
  logic [1:0] tam_out, part_si, part_ce;

  int checks = 0, failures = 0;
  logic done = 1'b0;

  // behavioural model state
  logic [L1-1:0] ch1 = '0;
  logic [L2-1:0] ch2 = '0;
  int  pos_m = 0;
  logic mode_m = 1'b0;
  logic prev_sh = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  flex_scan_wrapper #(.L1(L1), .L2(L2)) uut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .shift_en(shift_en),
    .mode_req(mode_req), .tam_in(tam_in), .tam_out(tam_out),
    .part_si(part_si), .part_so(part_so), .part_ce(part_ce)
  );

  task automatic step(input logic tm, input logic sh, input logic mr, input string force_tag);
    logic [1:0] ti, ce_e, si_e, to_e;
    string tag;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ti = lfsr[1:0];
    test_mode = tm; shift_en = sh; mode_req = mr; tam_in = ti;
    part_so = {ch2[L2-1], ch1[L1-1]};
    #1;
    ce_e = 2'b11; si_e = 2'b00; to_e = 2'b00;
    if (!tm) tag = "R9";
    else if (!sh) tag = "R10";
    else if (mode_m) begin
      tag = "R6"; si_e = ti; to_e = part_so;
    end else if (pos_m < L1) begin
      tag = (pos_m == 0) ? (prev_sh ? "R4" : "R5") : "R2";
      ce_e = 2'b01; si_e = {1'b0, ti[0]}; to_e = {1'b0, part_so[0]};
    end else begin
      tag = "R3";
      ce_e = 2'b10; si_e = {ti[0], 1'b0}; to_e = {1'b0, part_so[1]};
    end
    if (tm && sh && mr != mode_m) tag = {tag, "/R8"};
    if (!mode_m) tag = {tag, "/R7"};
    if (force_tag != "") tag = force_tag;
    checks++;
    if ({part_ce, part_si, tam_out} !== {ce_e, si_e, to_e}) begin
      failures++;
      $display("FAIL %s ce/si/out actual=%b_%b_%b expected=%b_%b_%b",
               tag, part_ce, part_si, tam_out, ce_e, si_e, to_e);
    end
    // advance model to the next edge
    if (tm && sh) begin
      if (ce_e[0]) ch1 = {ch1[L1-2:0], si_e[0]};
      if (ce_e[1]) ch2 = {ch2[L2-2:0], si_e[1]};
    end
    if (tm && sh && !mode_m) pos_m = (pos_m == TOTAL - 1) ? 0 : pos_m + 1;
    else pos_m = 0;
    if (!sh) mode_m = mr;
    prev_sh = tm && sh;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1, 0, 0, "R1");
    step(1, 0, 0, "R1");
    // long single-mode run: phase split and wrap
    for (int i = 0; i < 2 * TOTAL + 3; i++) step(1, 1, 0, "");
    step(1, 0, 0, "");
    // short bursts with idle gaps: restart
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < L1 + 1; i++) step(1, 1, 0, "");
      step(1, 0, 0, "");
    end
    // request dual during shifting: deferred
    for (int i = 0; i < TOTAL + 2; i++) step(1, 1, 1, "");
    step(1, 0, 1, "");
    for (int i = 0; i < 12; i++) step(1, 1, 1, "");
    // request single during dual shifting: deferred
    for (int i = 0; i < 4; i++) step(1, 1, 0, "");
    step(1, 0, 0, "");
    // functional mode with shift-enable toggling
    for (int i = 0; i < 6; i++) step(0, i[0], i[1], "");
    step(1, 0, 0, "");
    for (int i = 0; i < TOTAL + 4; i++) step(1, 1, 0, "");
    step(1, 0, 1, "");
    for (int i = 0; i < 5; i++) step(1, 1, 1, "");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule